// File: doc/BRIEF.md
# Frame-Based Transmit Event Scheduler

This block decides when outgoing cells are built for circuit-emulation channels. It holds a small table of events, grouped into a programmable number of frames with a programmable number of events in each. A frame pulse, nominally every 125 µs (one byte time per TDM channel), starts a scan of the current frame. The scan walks that frame's events in index order. Every event whose valid bit is set produces one cell-build request carrying the event's channel, the configured cell type and the current frame index. The request is held until a downstream assembler acknowledges it.

The current frame moves on at the later of two moments: the arrival of the next frame pulse, or the completion of the frame's last event. The counter steps through the frames in order and wraps to frame 0 after the last configured frame, so the table behaves as a continuously turning wheel. A pulse that arrives during a scan is kept as pending. Further pulses beyond that one are counted as overruns. Configuration changes made during a scan apply from the next frame boundary. Clearing the enable stops all requests and returns the wheel to frame 0.

Top module: `tx_event_sched`

## Requirements
- R1: Each table entry holds a valid bit and a channel number, written through the table write port. The entry for event index e of frame f is at address (base + f*(events per frame) + e) modulo the table depth, where events per frame = cfg_ev_last+1.
- R2: A frame pulse starts a scan of the current frame in ascending event index. Each valid entry yields exactly one request with its channel, and an entry whose valid bit is clear yields no request.
- R3: A request stays asserted, with channel, type and frame unchanged, until req_ack is seen high in the same cycle. Each acknowledged request consumes one event.
- R4: The frame counter advances only when both the next frame pulse has arrived and the last event of the current frame has been served. If the scan is complete and no pulse has come, no request is issued.
- R5: Frames are visited in order 0,1,…,cfg_last_frame, after which the counter wraps to 0.
- R6: A frame pulse received while a scan is running is held as pending. When the scan completes, the next frame's scan starts at once without another pulse.
- R7: Each frame pulse received during a scan while a pulse is already pending increments ovr_count by one. The counter saturates at its maximum and never decreases except on reset.
- R8: While cfg_enable is low, no request is issued from the following cycle on, the frame counter returns to 0 and any pending pulse is dropped. The first pulse after re-enabling scans frame 0.
- R9: req_type carries the configured cell type: 0 = AAL1 with pointer, 1 = AAL1 without pointer, 2 = CBR-AAL0, 3 = AAL5 voice.
- R10: cfg_base, cfg_last_frame, cfg_ev_last and cfg_type are sampled when a frame's scan starts. Changes made during a scan apply from the next frame.
- R11: After reset no request is asserted, ovr_count is 0 and the first pulse scans frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Scheduler enable |
| cfg_base | input | AW | Table base address |
| cfg_last_frame | input | FW | Index of the last frame (frame count minus one) |
| cfg_ev_last | input | EW | Index of the last event in a frame (events per frame minus one) |
| cfg_type | input | 2 | Cell type code sent with every request |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | AW | Table write address |
| tbl_valid | input | 1 | Valid bit to write |
| tbl_chan | input | CW | Channel number to write |
| frame_pulse | input | 1 | One-cycle frame pulse |
| req_valid | output | 1 | Cell-build request |
| req_ack | input | 1 | Request acknowledge |
| req_chan | output | CW | Channel of the request |
| req_type | output | 2 | Cell type of the request |
| req_frame | output | FW | Frame index of the request |
| ovr_count | output | OW | Saturating count of overrun pulses |

## Verification
A frame pulse sampled at one clock edge puts the scan in progress after that edge. A valid event at index 0 therefore shows its request during the next cycle, and each skipped invalid entry adds one cycle before the next request. An acknowledge is consumed at the edge where it is high, and the following event appears after that edge. An extra pulse shows up in ovr_count one edge later, and disabling clears the request one edge after cfg_enable falls. The bench drives and samples on the falling clock edge. It waits for each request with a bounded poll rather than a fixed delay. Quiet checks for "no request" are made only after enough cycles for any skip sequence to finish.

// File: rtl/tes_pkg.sv
package tes_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WAIT = 2'd2
  } sched_state_e;

  localparam int CELL_TYPE_W = 2;

endpackage

// File: rtl/tes_event_mem.sv
module tes_event_mem #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wvalid,
  input  logic [CW-1:0] wchan,
  input  logic [AW-1:0] raddr,
  output logic          rvalid,
  output logic [CW-1:0] rchan
);

  logic [DEPTH-1:0] vld_q;
  logic [CW-1:0]    chan_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic hit;
    assign hit = we && (waddr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
      end else if (hit) begin
        vld_q[i] <= wvalid;
      end
    end

    always_ff @(posedge clk) begin
      if (hit) begin
        chan_q[i] <= wchan;
      end
    end
  end

  assign rvalid = vld_q[raddr];
  assign rchan  = chan_q[raddr];

endmodule

// File: rtl/tes_addr_gen.sv
module tes_addr_gen #(
  parameter int AW = 5,
  parameter int FW = 3,
  parameter int EW = 2
) (
  input  logic [AW-1:0] base,
  input  logic [FW-1:0] frame,
  input  logic [EW-1:0] ev_last,
  input  logic [EW-1:0] ev_idx,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] stride;
  logic [AW-1:0] frame_off;

  always_comb begin
    stride    = AW'(ev_last) + AW'(1);
    frame_off = AW'(frame) * stride;
    addr      = base + frame_off + AW'(ev_idx);
  end

endmodule

// File: rtl/tes_frame_ctrl.sv
module tes_frame_ctrl
  import tes_pkg::*;
#(
  parameter int AW = 5,
  parameter int FW = 3,
  parameter int EW = 2,
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic [AW-1:0] cfg_base,
  input  logic [FW-1:0] cfg_last_frame,
  input  logic [EW-1:0] cfg_ev_last,
  input  logic [1:0]    cfg_type,
  input  logic          frame_pulse,
  input  logic          ev_valid,
  input  logic          req_ack,
  output logic          req_valid,
  output logic [FW-1:0] frame_idx,
  output logic [EW-1:0] ev_idx,
  output logic [AW-1:0] base_sh,
  output logic [EW-1:0] ev_last_sh,
  output logic [1:0]    type_sh,
  output logic [OW-1:0] ovr_count
);

  sched_state_e  state_q, state_d;
  logic [FW-1:0] frame_q, frame_d;
  logic [EW-1:0] ev_q, ev_d;
  logic          pend_q, pend_d;
  logic [AW-1:0] base_q, base_d;
  logic [FW-1:0] last_q, last_d;
  logic [EW-1:0] evl_q, evl_d;
  logic [1:0]    type_q, type_d;
  logic [OW-1:0] ovr_q, ovr_d;

  logic          scanning, step, last_ev, finish, pend_any, ovr_hit, load_cfg;
  logic [FW-1:0] frame_adv;

  always_comb begin
    scanning  = (state_q == ST_SCAN);
    step      = scanning && (!ev_valid || req_ack);
    last_ev   = (ev_q == evl_q);
    finish    = step && last_ev;
    pend_any  = pend_q || frame_pulse;
    ovr_hit   = cfg_enable && scanning && frame_pulse && pend_q;
    frame_adv = (frame_q >= cfg_last_frame) ? '0 : frame_q + FW'(1);
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    frame_d  = frame_q;
    ev_d     = ev_q;
    pend_d   = pend_q;
    load_cfg = 1'b0;
    if (!cfg_enable) begin
      state_d = ST_IDLE;
      frame_d = '0;
      ev_d    = '0;
      pend_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (frame_pulse) begin
            state_d  = ST_SCAN;
            frame_d  = '0;
            ev_d     = '0;
            load_cfg = 1'b1;
          end
        end
        ST_SCAN: begin
          if (finish) begin
            ev_d   = '0;
            pend_d = 1'b0;
            if (pend_any) begin
              frame_d  = frame_adv;
              load_cfg = 1'b1;
            end else begin
              state_d = ST_WAIT;
            end
          end else begin
            pend_d = pend_any;
            if (step) begin
              ev_d = ev_q + EW'(1);
            end
          end
        end
        ST_WAIT: begin
          if (frame_pulse) begin
            state_d  = ST_SCAN;
            frame_d  = frame_adv;
            ev_d     = '0;
            load_cfg = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    base_d = load_cfg ? cfg_base       : base_q;
    last_d = load_cfg ? cfg_last_frame : last_q;
    evl_d  = load_cfg ? cfg_ev_last    : evl_q;
    type_d = load_cfg ? cfg_type       : type_q;
    ovr_d  = ovr_q;
    if (ovr_hit && (ovr_q != '1)) begin
      ovr_d = ovr_q + OW'(1);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frame_q <= '0;
      ev_q    <= '0;
      pend_q  <= 1'b0;
      base_q  <= '0;
      last_q  <= '0;
      evl_q   <= '0;
      type_q  <= '0;
      ovr_q   <= '0;
    end else begin
      state_q <= state_d;
      frame_q <= frame_d;
      ev_q    <= ev_d;
      pend_q  <= pend_d;
      base_q  <= base_d;
      last_q  <= last_d;
      evl_q   <= evl_d;
      type_q  <= type_d;
      ovr_q   <= ovr_d;
    end
  end

  assign req_valid  = scanning && ev_valid;
  assign frame_idx  = frame_q;
  assign ev_idx     = ev_q;
  assign base_sh    = base_q;
  assign ev_last_sh = evl_q;
  assign type_sh    = type_q;
  assign ovr_count  = ovr_q;

  // R4 / R5: frame counter moves by one step or wraps to zero
  a_r4_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_q != $past(frame_q)) |-> ((frame_q == $past(frame_q) + FW'(1)) || (frame_q == '0)));

  // R5: the scanned frame never exceeds the last frame sampled for it
  a_r5_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN) |-> (frame_q <= last_q));

  // R4: a finished frame waits for a pulse
  a_r4_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !frame_pulse && cfg_enable) |=> (state_q == ST_WAIT));

  // R7: overrun counter never decreases
  a_r7_ovr_mono: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q >= $past(ovr_q));

endmodule

// File: rtl/tx_event_sched.sv
module tx_event_sched
  import tes_pkg::*;
#(
  parameter int FRAMES = 8,
  parameter int EVENTS = 4,
  parameter int DEPTH  = 32,
  parameter int CW     = 5,
  parameter int OW     = 4,
  localparam int FW    = $clog2(FRAMES),
  localparam int EW    = $clog2(EVENTS),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic [AW-1:0] cfg_base,
  input  logic [FW-1:0] cfg_last_frame,
  input  logic [EW-1:0] cfg_ev_last,
  input  logic [1:0]    cfg_type,
  input  logic          tbl_we,
  input  logic [AW-1:0] tbl_addr,
  input  logic          tbl_valid,
  input  logic [CW-1:0] tbl_chan,
  input  logic          frame_pulse,
  output logic          req_valid,
  input  logic          req_ack,
  output logic [CW-1:0] req_chan,
  output logic [1:0]    req_type,
  output logic [FW-1:0] req_frame,
  output logic [OW-1:0] ovr_count
);

  logic [AW-1:0] rd_addr;
  logic          ev_valid;
  logic [CW-1:0] ev_chan;
  logic [FW-1:0] frame_idx;
  logic [EW-1:0] ev_idx;
  logic [AW-1:0] base_sh;
  logic [EW-1:0] ev_last_sh;
  logic [1:0]    type_sh;

  tes_frame_ctrl #(.AW(AW), .FW(FW), .EW(EW), .OW(OW)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_enable     (cfg_enable),
    .cfg_base       (cfg_base),
    .cfg_last_frame (cfg_last_frame),
    .cfg_ev_last    (cfg_ev_last),
    .cfg_type       (cfg_type),
    .frame_pulse    (frame_pulse),
    .ev_valid       (ev_valid),
    .req_ack        (req_ack),
    .req_valid      (req_valid),
    .frame_idx      (frame_idx),
    .ev_idx         (ev_idx),
    .base_sh        (base_sh),
    .ev_last_sh     (ev_last_sh),
    .type_sh        (type_sh),
    .ovr_count      (ovr_count)
  );

  tes_addr_gen #(.AW(AW), .FW(FW), .EW(EW)) u_addr (
    .base    (base_sh),
    .frame   (frame_idx),
    .ev_last (ev_last_sh),
    .ev_idx  (ev_idx),
    .addr    (rd_addr)
  );

  tes_event_mem #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (tbl_we),
    .waddr  (tbl_addr),
    .wvalid (tbl_valid),
    .wchan  (tbl_chan),
    .raddr  (rd_addr),
    .rvalid (ev_valid),
    .rchan  (ev_chan)
  );

  assign req_chan  = ev_chan;
  assign req_type  = type_sh;
  assign req_frame = frame_idx;

  // R3: an unacknowledged request holds its contents
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n || !cfg_enable)
    (req_valid && !req_ack && !tbl_we) |=>
      (req_valid && $stable(req_chan) && $stable(req_type) && $stable(req_frame)));

  // R8: disabling silences requests from the next cycle
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !req_valid);

endmodule

// File: tb/tb_tx_event_sched.sv
module tb_tx_event_sched;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 5;
  localparam int FW = 3;
  localparam int EW = 2;
  localparam int AW = 5;
  localparam int OW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_enable;
  logic [AW-1:0] cfg_base;
  logic [FW-1:0] cfg_last_frame;
  logic [EW-1:0] cfg_ev_last;
  logic [1:0]    cfg_type;
  logic          tbl_we;
  logic [AW-1:0] tbl_addr;
  logic          tbl_valid;
  logic [CW-1:0] tbl_chan;
  logic          frame_pulse;
  logic          req_valid;
  logic          req_ack;
  logic [CW-1:0] req_chan;
  logic [1:0]    req_type;
  logic [FW-1:0] req_frame;
  logic [OW-1:0] ovr_count;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_event_sched dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_base(cfg_base),
    .cfg_last_frame(cfg_last_frame), .cfg_ev_last(cfg_ev_last), .cfg_type(cfg_type),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_valid(tbl_valid), .tbl_chan(tbl_chan),
    .frame_pulse(frame_pulse), .req_valid(req_valid), .req_ack(req_ack),
    .req_chan(req_chan), .req_type(req_type), .req_frame(req_frame), .ovr_count(ovr_count)
  );

  // {pulse first, channel, frame} expected in order
  localparam logic [8:0] VEC [7] = '{
    {1'b1, 5'd1, 3'd0}, {1'b0, 5'd2, 3'd0},
    {1'b1, 5'd3, 3'd1},
    {1'b1, 5'd4, 3'd2}, {1'b0, 5'd5, 3'd2},
    {1'b1, 5'd1, 3'd0}, {1'b0, 5'd2, 3'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input bit v, input int ch);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = AW'(a); tbl_valid = v; tbl_chan = CW'(ch);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    frame_pulse = 1'b1;
    @(negedge clk);
    frame_pulse = 1'b0;
  endtask

  task automatic wait_req(output bit found);
    found = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (req_valid) begin
        found = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic ack();
    req_ack = 1'b1;
    @(negedge clk);
    req_ack = 1'b0;
  endtask

  task automatic serve(input string tag, input int ch, input int fr, input int ty);
    bit found;
    wait_req(found);
    chk({tag, " request seen"}, int'(found), 1);
    chk({tag, " channel"}, int'(req_chan), ch);
    chk({tag, " frame"}, int'(req_frame), fr);
    chk({tag, " type"}, int'(req_type), ty);
    ack();
  endtask

  task automatic quiet(input string tag, input int cycles);
    for (int i = 0; i < cycles; i++) @(negedge clk);
    chk({tag, " no request"}, int'(req_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_enable = 1'b0; cfg_base = '0; cfg_last_frame = 3'd2;
    cfg_ev_last = 2'd3; cfg_type = 2'd2; tbl_we = 1'b0; tbl_addr = '0;
    tbl_valid = 1'b0; tbl_chan = '0; frame_pulse = 1'b0; req_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 req after reset", int'(req_valid), 0);
    chk("R11 ovr after reset", int'(ovr_count), 0);
    rst_n = 1'b1;

    // R1 table: frame0 addr0 ch1, addr2 ch2; frame1 addr7 ch3; frame2 addr8 ch4, addr9 ch5
    wr(0, 1'b1, 1); wr(1, 1'b0, 0); wr(2, 1'b1, 2);
    wr(7, 1'b1, 3); wr(8, 1'b1, 4); wr(9, 1'b1, 5);
    cfg_enable = 1'b1;

    // R2/R5/R9 table walk
    for (int k = 0; k < 7; k++) begin
      if (VEC[k][8]) begin
        if (k > 0) quiet("R4 before pulse", 8);
        pulse();
      end
      if (k == 0) begin
        bit found;
        wait_req(found);
        for (int h = 0; h < 3; h++) begin
          @(negedge clk);
          chk("R3 held", int'(req_valid), 1);
          chk("R3 chan stable", int'(req_chan), 1);
        end
      end
      serve("R2 walk", int'(VEC[k][7:3]), int'(VEC[k][2:0]), 2);
    end
    quiet("R4 after wrap", 8);

    // R6 pending + R7 overrun
    pulse();
    begin
      bit found;
      wait_req(found);
      chk("R6 frame1 req", int'(found), 1);
    end
    pulse();
    pulse();
    pulse();
    @(negedge clk);
    chk("R7 overrun count", int'(ovr_count), 2);
    chk("R3 still held", int'(req_valid), 1);
    ack();
    serve("R6 auto start", 4, 2, 2);
    serve("R6 second", 5, 2, 2);
    quiet("R6 no pending left", 8);

    // R10 mid-scan config change
    wr(16, 1'b1, 10); wr(20, 1'b1, 9);
    pulse();
    serve("R10 first", 1, 0, 2);
    cfg_base = 5'd16; cfg_type = 2'd0; cfg_last_frame = 3'd1;
    serve("R10 old base kept", 2, 0, 2);
    quiet("R10 wait", 8);
    pulse();
    serve("R10 new base", 9, 1, 0);
    quiet("R5 wait", 8);
    pulse();
    serve("R5 wrap at new count", 10, 0, 0);

    // R8 disable
    quiet("R8 wait", 8);
    pulse();
    begin
      bit found;
      wait_req(found);
      chk("R8 frame1 req", int'(found), 1);
      chk("R8 frame1 idx", int'(req_frame), 1);
    end
    cfg_enable = 1'b0;
    @(negedge clk);
    chk("R8 disabled req", int'(req_valid), 0);
    pulse();
    quiet("R8 disabled pulse", 5);
    cfg_enable = 1'b1;
    pulse();
    serve("R8 restart frame0", 10, 0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule